// File: doc/BRIEF.md
# Suspect-Wire Vote Scoreboard

This block keeps a vote count for every wire of every link in a 4-by-4 mesh of routers. The mesh has 48 one-way links of 64 wires each, so there are 3072 counters. When an endpoint decoder sees the same bit position fail often enough within one packet, it sends a suspect report to the block. The report gives the packet's source node, its destination node and the bit position. Routing is dimension-ordered: X first, then Y. The block therefore rebuilds the exact path of the packet from the two node numbers and adds one vote to the reported bit on every link of that path.

The block follows the highest count continuously and shows where it sits. When that count reaches a programmable threshold, the block raises a diagnose flag. Software sends an aging command from time to time, which lowers every nonzero count by one. Votes from transient faults therefore fade away, while a wire that is really broken keeps gathering votes. After a wire has been replaced by a spare, a clear command zeroes that wire's counter. The search then moves on to the next suspect.

The counters live in a single memory and are updated by read-modify-write. A report walks its route one link per clock cycle. Aging, and any rescan needed after a clear, step through all entries one per cycle. New commands are held off while either of these is running.

Top module: `wire_vote_board`

## Requirements
- R1: After reset the block is busy for one pass over all 3072 entries, which zeroes every counter. When that pass ends, top_cnt is 0, the top location is link 0 bit 0, and diag_valid is low.
- R2: A node number is y*4+x, with x in bits 1:0 and y in bits 3:2. A report first visits the links that step x toward the destination, then the links that step y toward it. It adds one vote on each of those links, in that order. When source and destination are equal, no counter changes.
- R3: Link numbers are as follows, where H=3 and G=12. An east hop from (x,y) is y*H+x. A west hop from (x,y) is G+y*H+x-1. A north hop (y+1) from (x,y) is 2G+x*H+y. A south hop (y-1) from (x,y) is 3G+x*H+y-1.
- R4: Counters are 8 bits wide. An increment of a counter already at 255 leaves it at 255.
- R5: A report is taken on a clock edge when rpt_valid and rpt_ready are both high. rpt_ready is high only when the block is idle and neither age_req nor clr_req is present. busy stays high while a route walk is in progress.
- R6: An accepted age_req lowers every nonzero counter by one and leaves zero counters at zero. Afterwards top_cnt equals the old top_cnt minus one, with a floor of 0.
- R7: An accepted clr_req sets the counter at (clr_link, clr_bit) to zero. If that wire held the top location, the block becomes busy with a rescan. Otherwise the top location and top_cnt are unchanged and busy stays low.
- R8: When the block is idle, clr_req takes priority over age_req, and age_req takes priority over a report. age_req and clr_req that arrive while busy is high are ignored.
- R9: top_cnt is always the largest counter value. During a walk, the top location moves only to a wire whose new count is strictly greater than the current top. After an aging pass or a rescan, the top location is the lowest address (link*64+bit) among the wires tied at the maximum.
- R10: diag_valid is high exactly when top_cnt is nonzero and top_cnt >= thr. diag_link and diag_bit give the top location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rpt_valid | input | 1 | Suspect report present |
| rpt_ready | output | 1 | Block takes a report on this edge |
| rpt_src | input | 4 | Source node, {y,x} |
| rpt_dst | input | 4 | Destination node, {y,x} |
| rpt_bit | input | 6 | Suspected bit position |
| age_req | input | 1 | Lower all nonzero counts by one |
| clr_req | input | 1 | Zero one wire's counter |
| clr_link | input | 6 | Link of the wire to clear |
| clr_bit | input | 6 | Bit of the wire to clear |
| thr | input | 8 | Vote threshold for diagnosis |
| busy | output | 1 | Walk or sweep in progress |
| diag_valid | output | 1 | Top count has reached the threshold |
| diag_link | output | 6 | Link of the top wire |
| diag_bit | output | 6 | Bit of the top wire |
| top_cnt | output | 8 | Highest counter value |

## Verification
The bench targets four kinds of corner case, each with its own failure signature.

- Routes are chosen to run in each of the four directions. A wrong link formula or the wrong order of dimensions would place the winning vote on a different link number.
- One wire is driven past 255. If saturation were missing, the counter would wrap to a small value and top_cnt would collapse.
- Clears are sent both to the top wire and to other wires. A missing rescan would leave a stale top, and a needless rescan would raise busy.
- Aging is checked on an empty array, where a counter that underflows would report 255. Aging is also raced against a report, and age and clear requests are pulsed during a walk. A wrong priority, or a request that leaks in while busy, would change the counts.

// File: rtl/wire_vote_board.sv
module wire_vote_board #(
  parameter int MESH   = 4,
  parameter int LINK_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rpt_valid,
  output logic                                  rpt_ready,
  input  logic [2*$clog2(MESH)-1:0]             rpt_src,
  input  logic [2*$clog2(MESH)-1:0]             rpt_dst,
  input  logic [$clog2(LINK_W)-1:0]             rpt_bit,
  input  logic                                  age_req,
  input  logic                                  clr_req,
  input  logic [$clog2(4*MESH*(MESH-1))-1:0]    clr_link,
  input  logic [$clog2(LINK_W)-1:0]             clr_bit,
  input  logic [CNT_W-1:0]                      thr,
  output logic                                  busy,
  output logic                                  diag_valid,
  output logic [$clog2(4*MESH*(MESH-1))-1:0]    diag_link,
  output logic [$clog2(LINK_W)-1:0]             diag_bit,
  output logic [CNT_W-1:0]                      top_cnt
);
  localparam int NW    = $clog2(MESH);
  localparam int HOPS  = MESH - 1;
  localparam int GRP   = MESH * HOPS;
  localparam int NLINK = 4 * GRP;
  localparam int LW    = $clog2(NLINK);
  localparam int BW    = $clog2(LINK_W);
  localparam int AW    = LW + BW;
  localparam int DEPTH = NLINK * LINK_W;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_SWEEP} st_t;
  typedef enum logic [1:0] {M_ZERO, M_AGE, M_SCAN} md_t;

  st_t state;
  md_t mode;
  logic [CNT_W-1:0] mem [DEPTH];
  logic [NW-1:0] cx, cy, dx, dy;
  logic [BW-1:0] wbit;
  logic [AW-1:0] idx, best_addr, top_addr;
  logic [CNT_W-1:0] best_val, top_val;

  // walk datapath
  logic hop_x, hop_y, hop, go_e, go_n;
  int   link_id;
  logic [AW-1:0] waddr, caddr;
  logic [CNT_W-1:0] rd, inc;

  assign hop_x = cx != dx;
  assign hop_y = cy != dy;
  assign hop   = hop_x | hop_y;
  assign go_e  = dx > cx;
  assign go_n  = dy > cy;
  assign link_id = hop_x ? (go_e ? int'(cy) * HOPS + int'(cx)
                                 : GRP + int'(cy) * HOPS + int'(cx) - 1)
                         : (go_n ? 2 * GRP + int'(cx) * HOPS + int'(cy)
                                 : 3 * GRP + int'(cx) * HOPS + int'(cy) - 1);
  assign waddr = {LW'(link_id), wbit};
  assign caddr = {clr_link, clr_bit};
  assign rd    = mem[waddr];
  assign inc   = (rd == '1) ? rd : rd + 1'b1;

  // sweep datapath
  logic [CNT_W-1:0] srd, sval;
  logic last;
  assign srd  = mem[idx];
  assign sval = (mode == M_ZERO) ? '0 :
                (mode == M_AGE)  ? ((srd == '0) ? srd : srd - 1'b1) : srd;
  assign last = idx == AW'(DEPTH - 1);

  // single write port
  logic we;
  logic [AW-1:0] wa;
  logic [CNT_W-1:0] wd;
  always_comb begin
    we = 1'b0;
    wa = idx;
    wd = sval;
    case (state)
      S_WALK:  begin we = hop; wa = waddr; wd = inc; end
      S_SWEEP: we = mode != M_SCAN;
      default: begin we = clr_req; wa = caddr; wd = '0; end
    endcase
  end

  always_ff @(posedge clk)
    if (we) mem[wa] <= wd;

  assign busy       = state != S_IDLE;
  assign rpt_ready  = (state == S_IDLE) && !clr_req && !age_req;
  assign diag_valid = (top_val != '0) && (top_val >= thr);
  assign diag_link  = top_addr[AW-1:BW];
  assign diag_bit   = top_addr[BW-1:0];
  assign top_cnt    = top_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_SWEEP;
      mode  <= M_ZERO;
      idx <= '0; best_addr <= '0; best_val <= '0;
      top_addr <= '0; top_val <= '0;
      cx <= '0; cy <= '0; dx <= '0; dy <= '0; wbit <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (clr_req) begin
            if (caddr == top_addr) begin
              state <= S_SWEEP; mode <= M_SCAN;
              idx <= '0; best_addr <= '0; best_val <= '0;
            end
          end else if (age_req) begin
            state <= S_SWEEP; mode <= M_AGE;
            idx <= '0; best_addr <= '0; best_val <= '0;
          end else if (rpt_valid) begin
            state <= S_WALK;
            cx <= rpt_src[NW-1:0]; cy <= rpt_src[2*NW-1:NW];
            dx <= rpt_dst[NW-1:0]; dy <= rpt_dst[2*NW-1:NW];
            wbit <= rpt_bit;
          end
        end
        S_WALK: begin
          if (!hop) state <= S_IDLE;
          else begin
            if (inc > top_val) begin
              top_val <= inc; top_addr <= waddr;
            end
            if (hop_x) cx <= go_e ? cx + 1'b1 : cx - 1'b1;
            else       cy <= go_n ? cy + 1'b1 : cy - 1'b1;
          end
        end
        default: begin
          if (sval > best_val) begin
            best_val <= sval; best_addr <= idx;
          end
          if (last) begin
            state <= S_IDLE;
            if (sval > best_val) begin
              top_val <= sval; top_addr <= idx;
            end else begin
              top_val <= best_val; top_addr <= best_addr;
            end
          end else idx <= idx + 1'b1;
        end
      endcase
    end
  end

  logic [$clog2(2*MESH)-1:0] walk_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) walk_len <= '0;
    else        walk_len <= (state == S_WALK) ? walk_len + 1'b1 : '0;

  p_walk_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WALK |-> int'(walk_len) <= 2 * HOPS);

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WALK && hop) |=> mem[$past(waddr)] != '0);

  p_top_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WALK |=> top_val >= $past(top_val));

  p_age_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWEEP && mode == M_AGE && last) |=>
      top_val == (($past(top_val) == '0) ? '0 : $past(top_val) - 1'b1));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && clr_req) |=> mem[$past(caddr)] == '0);
endmodule

// File: tb/wire_vote_board_tb.sv
module wire_vote_board_tb;
  localparam int MESH = 4, LINK_W = 64, H = 3, G = 12, NLINK = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rpt_valid, rpt_ready, age_req, clr_req, busy, diag_valid;
  logic [3:0] rpt_src, rpt_dst;
  logic [5:0] rpt_bit, clr_link, clr_bit, diag_link, diag_bit;
  logic [7:0] thr, top_cnt;

  wire_vote_board u_dut (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_src(rpt_src), .rpt_dst(rpt_dst), .rpt_bit(rpt_bit),
    .age_req(age_req), .clr_req(clr_req), .clr_link(clr_link), .clr_bit(clr_bit),
    .thr(thr), .busy(busy), .diag_valid(diag_valid), .diag_link(diag_link),
    .diag_bit(diag_bit), .top_cnt(top_cnt));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int cnt [NLINK][LINK_W];
  int mval, mlink, mbit;
  int rt [8];
  int rt_n;

  function automatic void route(int s, int d);
    int x = s % 4, y = s / 4, tx = d % 4, ty = d / 4;
    rt_n = 0;
    while (x != tx) begin
      if (tx > x) begin rt[rt_n] = y*H + x; x++; end
      else        begin rt[rt_n] = G + y*H + x - 1; x--; end
      rt_n++;
    end
    while (y != ty) begin
      if (ty > y) begin rt[rt_n] = 2*G + x*H + y; y++; end
      else        begin rt[rt_n] = 3*G + x*H + y - 1; y--; end
      rt_n++;
    end
  endfunction

  function automatic void m_rescan();
    mval = 0; mlink = 0; mbit = 0;
    for (int l = 0; l < NLINK; l++)
      for (int b = 0; b < LINK_W; b++)
        if (cnt[l][b] > mval) begin mval = cnt[l][b]; mlink = l; mbit = b; end
  endfunction

  function automatic void m_report(int s, int d, int b);
    route(s, d);
    for (int i = 0; i < rt_n; i++) begin
      if (cnt[rt[i]][b] < 255) cnt[rt[i]][b]++;
      if (cnt[rt[i]][b] > mval) begin mval = cnt[rt[i]][b]; mlink = rt[i]; mbit = b; end
    end
  endfunction

  function automatic void m_age();
    for (int l = 0; l < NLINK; l++)
      for (int b = 0; b < LINK_W; b++)
        if (cnt[l][b] > 0) cnt[l][b]--;
    m_rescan();
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_top(string tag);
    chk({tag, " top_cnt R9"}, int'(top_cnt), mval);
    chk({tag, " diag_link R9"}, int'(diag_link), mlink);
    chk({tag, " diag_bit R9"}, int'(diag_bit), mbit);
    chk({tag, " diag_valid R10"}, int'(diag_valid),
        int'(mval != 0 && mval >= int'(thr)));
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_rpt(int s, int d, int b);
    wait_idle();
    rpt_src = 4'(s); rpt_dst = 4'(d); rpt_bit = 6'(b); rpt_valid = 1'b1;
    @(negedge clk);
    rpt_valid = 1'b0;
    m_report(s, d, b);
    wait_idle();
  endtask

  task automatic do_age();
    wait_idle();
    age_req = 1'b1;
    @(negedge clk);
    age_req = 1'b0;
    m_age();
    wait_idle();
  endtask

  task automatic do_clr(int l, int b);
    wait_idle();
    clr_link = 6'(l); clr_bit = 6'(b); clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    cnt[l][b] = 0;
    if (l == mlink && b == mbit) m_rescan();
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R5: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd61819);
    rst_n = 1'b0; rpt_valid = 1'b0; age_req = 1'b0; clr_req = 1'b0;
    rpt_src = '0; rpt_dst = '0; rpt_bit = '0; clr_link = '0; clr_bit = '0;
    thr = 8'd1;
    for (int l = 0; l < NLINK; l++)
      for (int b = 0; b < LINK_W; b++) cnt[l][b] = 0;
    mval = 0; mlink = 0; mbit = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy during init pass", int'(busy), 1);
    wait_idle();
    check_top("R1 after init");
    thr = 8'd0;
    @(negedge clk);
    chk("R10 zero top with thr 0", int'(diag_valid), 0);
    thr = 8'd1;

    do_age();
    check_top("R6 age on empty array floors at zero");

    do_rpt(0, 15, 12);
    check_top("R2 first report");
    chk("R3 east link 0", int'(diag_link), 0);
    do_rpt(3, 15, 12);
    check_top("R3 north");
    chk("R3 north link from (3,0)", int'(diag_link), 33);
    repeat (3) do_rpt(15, 12, 7);
    check_top("R3 west");
    chk("R3 west link from (3,3)", int'(diag_link), 23);
    repeat (4) do_rpt(12, 0, 9);
    check_top("R3 south");
    chk("R3 south link from (0,3)", int'(diag_link), 38);
    repeat (5) do_rpt(0, 5, 50);
    check_top("R2 x before y");
    chk("R2 x hop first", int'(diag_link), 0);
    chk("R2 count five", int'(top_cnt), 5);

    do_rpt(5, 5, 1);
    check_top("R2 same node no change");

    thr = 8'd6;
    @(negedge clk);
    check_top("R10 below threshold");
    thr = 8'd5;
    @(negedge clk);
    check_top("R10 at threshold");

    wait_idle();
    age_req = 1'b1; rpt_valid = 1'b1; rpt_src = 4'd0; rpt_dst = 4'd1; rpt_bit = 6'd50;
    #1;
    chk("R8 report held off by age", int'(rpt_ready), 0);
    @(negedge clk);
    age_req = 1'b0; rpt_valid = 1'b0;
    m_age();
    wait_idle();
    check_top("R8 age wins over report");
    chk("R6 top after age", int'(top_cnt), 4);

    wait_idle();
    rpt_src = 4'd0; rpt_dst = 4'd15; rpt_bit = 6'd20; rpt_valid = 1'b1;
    @(negedge clk);
    rpt_valid = 1'b0;
    chk("R5 busy in walk", int'(busy), 1);
    chk("R5 ready low in walk", int'(rpt_ready), 0);
    clr_link = 6'(mlink); clr_bit = 6'(mbit); clr_req = 1'b1; age_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0; age_req = 1'b0;
    m_report(0, 15, 20);
    wait_idle();
    check_top("R8 requests ignored while busy");

    wait_idle();
    clr_link = 6'd47; clr_bit = 6'd0; clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    cnt[47][0] = 0;
    chk("R7 non-top clear no rescan", int'(busy), 0);
    check_top("R7 non-top clear");

    do_clr(mlink, mbit);
    check_top("R7 top clear rescans");

    for (int i = 0; i < 260; i++) do_rpt(0, 1, 63);
    thr = 8'd255;
    @(negedge clk);
    check_top("R4 saturation");
    chk("R4 count held at 255", int'(top_cnt), 255);
    do_age();
    check_top("R6 age from saturation");
    do_clr(0, 63);
    check_top("R7 clear saturated wire");
    thr = 8'd3;

    for (int i = 0; i < 150; i++) begin
      int r = $urandom_range(99, 0);
      if (r < 6) do_age();
      else if (r < 11) do_clr(mlink, mbit);
      else if (r < 16) do_clr($urandom_range(NLINK-1, 0), $urandom_range(LINK_W-1, 0));
      else begin
        int b = $urandom_range(2, 0);
        b = (b == 0) ? 12 : (b == 1) ? 40 : $urandom_range(LINK_W-1, 0);
        do_rpt($urandom_range(15, 0), $urandom_range(15, 0), b);
      end
      if (r % 10 == 0) thr = 8'($urandom_range(6, 1));
      @(negedge clk);
      check_top("R9 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule